// File: doc/BRIEF.md
# Arbitrary-Ratio Bit Gearbox

The gearbox takes a stream of `IN_W`-bit words and delivers the same bits as a stream of `OUT_W`-bit words. The two widths are independent parameters and need not divide one another, so pairs such as 3 to 6 or 5 to 3 work. Both sides use a valid/ready handshake. When an input word is accepted, it is appended to a circular bit store of `BUF_W` bits. A write pointer marks where the next bits go. A read pointer marks the oldest bit not yet sent. An occupancy counter records how many bits are held.

An output word is offered whenever at least `OUT_W` bits are held. It is formed from the `OUT_W` bits that start at the read pointer, and it wraps past the top of the store when needed. An input word is accepted only when at least `IN_W` bits of the store are free. Bit 0 of each word is the earliest bit in the serial stream, on both sides. The store must hold at least `IN_W + OUT_W - 1` bits. With less, the block can reach a state where it neither accepts nor offers data.

Top module: `bit_gearbox`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o` is low and `ready_o` is high; the store counts as empty.
- R2: `ready_o` is high exactly when the number of free bits (`BUF_W` minus occupancy) is at least `IN_W`.
- R3: `valid_o` is high exactly when occupancy is at least `OUT_W`.
- R4: Bits leave in the order they enter, LSB-first on both sides. Input bit `i` of a word follows input bit `i-1`, and output bit `j` of a word follows output bit `j-1`.
- R5: While `valid_o` is high and `ready_i` is low, at the next clock edge `valid_o` stays high and `data_o` is unchanged.
- R6: When an input and an output handshake complete in the same cycle, occupancy changes by `IN_W - OUT_W`, and both flags follow R2 and R3 from then on.
- R7: With `BUF_W >= IN_W + OUT_W - 1`, at least one of `ready_o` and `valid_o` is high in every cycle.
- R8: An output word whose span crosses the top of the store takes its low bits from the top positions and its remaining bits from position 0 upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word offered |
| data_i | input | IN_W | Input word, bit 0 earliest |
| ready_o | output | 1 | Room for one input word |
| valid_o | output | 1 | Output word available |
| data_o | output | OUT_W | Output word, bit 0 earliest |
| ready_i | input | 1 | Downstream takes the output word |

## Verification
The checker keeps its own occupancy count, built only from the two handshakes at the ports. It therefore assumes that `valid_i` and `ready_i` are known (not X) at every sampled edge. It also assumes the default configuration meets the minimum store size that the no-stall property needs. The bench drives both inputs to defined values on every falling edge, from the first one through the end of the run. It feeds a pseudo-random bit stream and throttles `valid_i` and `ready_i` at several rates. These include a phase in which `ready_i` is held low long enough to fill the store, and a drain phase afterwards.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  // Reduce a sum below 2*m into [0, m).
  function automatic int unsigned wrap_once(input int unsigned a, input int unsigned m);
    return (a >= m) ? a - m : a;
  endfunction
endpackage

// File: rtl/gbx_ptr.sv
module gbx_ptr #(
  parameter int STEP  = 3,
  parameter int BUF_W = 16,
  parameter int PTR_W = $clog2(BUF_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W:0] STEP_L = (PTR_W+1)'(STEP);
  localparam logic [PTR_W:0] SIZE_L = (PTR_W+1)'(BUF_W);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W:0]   sum;
  logic [PTR_W:0]   nxt;

  always_comb begin
    sum = {1'b0, ptr_q} + STEP_L;
    nxt = (sum >= SIZE_L) ? sum - SIZE_L : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= nxt[PTR_W-1:0];
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/gbx_store.sv
module gbx_store #(
  parameter int IN_W  = 3,
  parameter int BUF_W = 16,
  parameter int PTR_W = $clog2(BUF_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wptr_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [BUF_W-1:0] bits_o
);
  localparam logic [PTR_W:0] SIZE_L = (PTR_W+1)'(BUF_W);

  logic [PTR_W-1:0] widx [IN_W];
  logic [BUF_W-1:0] mem_q;

  for (genvar gi = 0; gi < IN_W; gi++) begin : g_widx
    logic [PTR_W:0] raw;
    assign raw = {1'b0, wptr_i} + (PTR_W+1)'(gi);
    assign widx[gi] = (raw >= SIZE_L) ? PTR_W'(raw - SIZE_L) : raw[PTR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < IN_W; i++) mem_q[widx[i]] <= data_i[i];
    end
  end

  assign bits_o = mem_q;
endmodule

// File: rtl/gbx_tap.sv
module gbx_tap #(
  parameter int OUT_W = 6,
  parameter int BUF_W = 16,
  parameter int PTR_W = $clog2(BUF_W)
) (
  input  logic [BUF_W-1:0] bits_i,
  input  logic [PTR_W-1:0] rptr_i,
  output logic [OUT_W-1:0] data_o
);
  localparam logic [PTR_W:0] SIZE_L = (PTR_W+1)'(BUF_W);

  for (genvar gj = 0; gj < OUT_W; gj++) begin : g_tap
    logic [PTR_W:0]   raw;
    logic [PTR_W-1:0] idx;
    assign raw = {1'b0, rptr_i} + (PTR_W+1)'(gj);
    assign idx = (raw >= SIZE_L) ? PTR_W'(raw - SIZE_L) : raw[PTR_W-1:0];
    assign data_o[gj] = bits_i[idx];
  end
endmodule

// File: rtl/gbx_level.sv
module gbx_level #(
  parameter int IN_W  = 3,
  parameter int OUT_W = 6,
  parameter int BUF_W = 16,
  parameter int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic rd_i,
  output logic space_ok_o,
  output logic data_ok_o
);
  localparam logic [CNT_W-1:0] ADD_L  = CNT_W'(IN_W);
  localparam logic [CNT_W-1:0] SUB_L  = CNT_W'(OUT_W);
  localparam logic [CNT_W-1:0] ROOM_L = CNT_W'(BUF_W - IN_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i) cnt_d = cnt_d + ADD_L;
    if (rd_i) cnt_d = cnt_d - SUB_L;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign space_ok_o = (cnt_q <= ROOM_L);
  assign data_ok_o  = (cnt_q >= SUB_L);
endmodule

// File: rtl/bit_gearbox.sv
module bit_gearbox #(
  parameter int IN_W  = 3,
  parameter int OUT_W = 6,
  parameter int BUF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             ready_o,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  input  logic             ready_i
);
  localparam int PTR_W = $clog2(BUF_W);
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic             wr_fire;
  logic             rd_fire;
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic [BUF_W-1:0] bits;

  assign wr_fire = valid_i & ready_o;
  assign rd_fire = valid_o & ready_i;

  gbx_ptr #(.STEP(IN_W), .BUF_W(BUF_W), .PTR_W(PTR_W)) u_wptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(wr_fire), .ptr_o(wptr)
  );

  gbx_ptr #(.STEP(OUT_W), .BUF_W(BUF_W), .PTR_W(PTR_W)) u_rptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rd_fire), .ptr_o(rptr)
  );

  gbx_store #(.IN_W(IN_W), .BUF_W(BUF_W), .PTR_W(PTR_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_fire), .wptr_i(wptr),
    .data_i(data_i), .bits_o(bits)
  );

  gbx_tap #(.OUT_W(OUT_W), .BUF_W(BUF_W), .PTR_W(PTR_W)) u_tap (
    .bits_i(bits), .rptr_i(rptr), .data_o(data_o)
  );

  gbx_level #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_level (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_fire), .rd_i(rd_fire),
    .space_ok_o(ready_o), .data_ok_o(valid_o)
  );
endmodule

// File: rtl/bit_gearbox_chk.sv
module bit_gearbox_chk #(
  parameter int IN_W  = 3,
  parameter int OUT_W = 6,
  parameter int BUF_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_o,
  input logic             valid_o,
  input logic [OUT_W-1:0] data_o,
  input logic             ready_i
);
  // Occupancy rebuilt from port handshakes only.
  int occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= 0;
    else occ_q <= occ_q + ((valid_i && ready_o) ? IN_W : 0)
                        - ((valid_o && ready_i) ? OUT_W : 0);
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && ready_o));

  assert_ready_space_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == ((BUF_W - occ_q) >= IN_W));

  assert_valid_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (occ_q >= OUT_W));

  assert_hold_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q >= 0) && (occ_q <= BUF_W));

  assert_no_deadlock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o || valid_o);
endmodule

bind bit_gearbox bit_gearbox_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_W(BUF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
  .valid_o(valid_o), .data_o(data_o), .ready_i(ready_i)
);

// File: tb/bit_gearbox_tb.sv
`timescale 1ns/1ps
module bit_gearbox_tb;
  localparam int IN_W  = 3;
  localparam int OUT_W = 6;
  localparam int BUF_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             valid_i;
  logic [IN_W-1:0]  data_i;
  logic             ready_o;
  logic             valid_o;
  logic [OUT_W-1:0] data_o;
  logic             ready_i;

  always #2.5 clk = ~clk;

  bit_gearbox #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_W(BUF_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .ready_o(ready_o), .valid_o(valid_o), .data_o(data_o), .ready_i(ready_i)
  );

  bit   exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  int   occ    = 0;
  int   rd_pos = 0;
  int   in_rate  = 0;
  int   out_rate = 0;
  bit   running  = 0;
  logic [15:0] prbs = 16'hACE1;
  int   cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [IN_W-1:0] prbs_word();
    logic [IN_W-1:0] w;
    for (int i = 0; i < IN_W; i++) begin
      prbs = {prbs[14:0], prbs[15] ^ prbs[13] ^ prbs[12] ^ prbs[10]};
      w[i] = prbs[0];
    end
    return w;
  endfunction

  // Driver: one cycle of input stimulus plus flag checks against the bench occupancy.
  task automatic drive_cycle();
    bit acc_in, acc_out;
    @(negedge clk);
    valid_i = ($urandom % 100) < in_rate;
    data_i  = prbs_word();
    #1;
    chk(ready_o == ((BUF_W - occ) >= IN_W), "R2 ready_o", ready_o, (BUF_W - occ) >= IN_W);
    chk(valid_o == (occ >= OUT_W), "R3 valid_o", valid_o, occ >= OUT_W);
    chk(valid_o || ready_o, "R7 stall-free", {valid_o, ready_o}, 1);
    acc_in  = valid_i && ready_o;
    acc_out = valid_o && ready_i;
    if (acc_in)
      for (int i = 0; i < IN_W; i++) exp_q.push_back(data_i[i]);
    occ = occ + (acc_in ? IN_W : 0) - (acc_out ? OUT_W : 0);
    if (acc_in && acc_out)
      chk(occ >= 0 && occ <= BUF_W, "R6 joint update", occ, BUF_W);
  endtask

  task automatic run_phase(input int ir, input int orr, input int n);
    in_rate  = ir;
    out_rate = orr;
    for (int k = 0; k < n; k++) drive_cycle();
  endtask

  // Monitor: drives ready_i, pops expected bits on each output handshake.
  logic [OUT_W-1:0] prev_data;
  bit               prev_stall = 0;
  always @(negedge clk) begin
    if (running) begin
      logic [OUT_W-1:0] exp_w;
      ready_i = ($urandom % 100) < out_rate;
      #1;
      if (prev_stall) begin
        chk(valid_o == 1'b1, "R5 valid held", valid_o, 1);
        chk(data_o == prev_data, "R5 data held", data_o, prev_data);
      end
      if (valid_o && ready_i) begin
        if (exp_q.size() < OUT_W) begin
          chk(0, "R4 underrun", exp_q.size(), OUT_W);
        end else begin
          for (int j = 0; j < OUT_W; j++) exp_w[j] = exp_q.pop_front();
          if (rd_pos + OUT_W > BUF_W)
            chk(data_o == exp_w, "R8 wrapped word", data_o, exp_w);
          else
            chk(data_o == exp_w, "R4 word order", data_o, exp_w);
        end
        rd_pos = (rd_pos + OUT_W) % BUF_W;
      end
      prev_stall = valid_o && !ready_i;
      prev_data  = data_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    data_i  = '0;
    ready_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(valid_o == 1'b0, "R1 valid_o in reset", valid_o, 0);
    chk(ready_o == 1'b1, "R1 ready_o in reset", ready_o, 1);
    rst_ni = 1'b1;
    #1;
    chk(valid_o == 1'b0, "R1 valid_o after release", valid_o, 0);
    running = 1;

    run_phase(100, 100, 300);  // full rate, joint handshakes
    run_phase(60, 40, 2000);
    run_phase(30, 90, 2000);
    run_phase(100, 0, 20);     // fill
    @(negedge clk); #1.5;
    chk(ready_o == 1'b0, "R2 full store", ready_o, 0);
    chk(valid_o == 1'b1, "R3 full store", valid_o, 1);
    run_phase(0, 100, 20);     // drain
    @(negedge clk); #1.5;
    chk(valid_o == 1'b0, "R3 drained", valid_o, 0);
    chk(ready_o == 1'b1, "R2 drained", ready_o, 1);
    run_phase(50, 50, 3000);
    run_phase(0, 100, 20);
    chk(exp_q.size() == occ, "R4 residual bits", exp_q.size(), occ);
    running = 0;
    finish_run();
  end
endmodule